// File: doc/BRIEF.md
# Flywheel Frame Synchronizer

This block follows the frame alignment of a serial bit stream. Its only input is a per-bit pulse from an upstream correlator saying that a sync word has just ended on this bit. A free-running bit counter of one frame length is aligned by the first such pulse. After that, it opens a three-bit window around the position where the next sync word should end.

A three-state machine (search, check, lock) adds hysteresis. Two consecutive hits inside the window are needed to gain lock. A single missed window drops the block from lock to check, and a further miss sends it back to search. A hit one bit early or one bit late still counts, and it realigns the counter so the next window is centred on the new position.

The outputs are the state, a lock flag, a frame-start strobe and a slip indication with its direction. All of them are registered.

Top module: `fsync_flywheel`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and on the first cycle after release, `state_o` is 0 (search) and every other output is 0. Asserting reset at any time returns the block to search.
- R2: In search, a detect pulse on any bit is accepted. On the next cycle `state_o` is 1 (check) and `frame_start_o` is 1.
- R3: The state moves from check to lock (`state_o` = 2) on the cycle after the LOCK_HITS-th consecutive in-window hit. LOCK_HITS defaults to 2, and it counts the hits that follow the acquiring pulse.
- R4: In check, a window that closes with no accepted hit returns the block to search on the cycle after the last window bit.
- R5: In lock, a window that closes with no hit moves the block to check. A single hit in the following window then restores lock.
- R6: From lock, two consecutive missed windows return the block to search. Lock never goes straight to search.
- R7: After an accepted sync on cycle t, the next window covers cycles t+FRAME_BITS-1, t+FRAME_BITS and t+FRAME_BITS+1. On the internal counter this is positions CENTER_POS-1 to CENTER_POS+1, with CENTER_POS = 19198 and FRAME_BITS = 19200 by default. A detect two bits early is not accepted.
- R8: A hit on the first or last window bit realigns the counter so that the next window is centred FRAME_BITS cycles after that hit. On the next cycle `slip_o` is 1, and `slip_late_o` is 1 for a late hit and 0 for an early one. Both outputs stay 0 for an on-time hit.
- R9: In check and lock, detect pulses outside the window change neither the state nor any output.
- R10: Only the first detect inside one window is accepted. A second detect in the same window has no effect.
- R11: `frame_start_o` is high for exactly the one cycle after each accepted sync and is never high on two cycles in a row.
- R12: `locked_o` is 1 exactly when `state_o` is 2 (lock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_det_i | input | 1 | Sync word detected, ending on this bit |
| state_o | output | 2 | 0 search, 1 check, 2 lock |
| locked_o | output | 1 | High while in lock |
| frame_start_o | output | 1 | One-cycle strobe after an accepted sync |
| slip_o | output | 1 | One-cycle strobe after an early or late hit |
| slip_late_o | output | 1 | With `slip_o`: 1 late, 0 early |

## Verification
Every output is registered once after the decision logic, so each result is due on the cycle right after the clock edge that samples the detect pulse. A miss shows up on the cycle after the last window bit. The bench drives the detect input on the falling edge, steps its reference model on the rising edge, and compares all five outputs 1 ns after that same edge. The model tracks the absolute cycle of the next expected sync rather than a modulo counter. This lets early, late and missed windows be predicted without copying the counter logic. A reduced frame length keeps many frames inside the run.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    FS_SEARCH = 2'd0,
    FS_CHECK  = 2'd1,
    FS_LOCK   = 2'd2
  } fs_state_e;
endpackage

// File: rtl/fsync_frame_ctr.sv
// Bit position counter over one frame with window decode.
module fsync_frame_ctr #(
  parameter int FRAME_BITS = 19200,
  parameter int CENTER_POS = 19198,
  parameter int CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic realign,
  output logic pos_early,
  output logic pos_center,
  output logic pos_late,
  output logic in_win
);
  localparam logic [CNT_W-1:0] EARLY_C  = CNT_W'(CENTER_POS - 1);
  localparam logic [CNT_W-1:0] CENTER_C = CNT_W'(CENTER_POS);
  localparam logic [CNT_W-1:0] LATE_C   = CNT_W'(CENTER_POS + 1);
  localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (realign)        cnt_q <= LATE_C;  // this bit becomes the centre
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign pos_early  = (cnt_q == EARLY_C);
  assign pos_center = (cnt_q == CENTER_C);
  assign pos_late   = (cnt_q == LATE_C);
  assign in_win     = pos_early | pos_center | pos_late;
endmodule

// File: rtl/fsync_window_gate.sv
// Decides whether a detect pulse is taken and whether a window was missed.
module fsync_window_gate (
  input  logic clk,
  input  logic rst,
  input  logic searching,
  input  logic det,
  input  logic in_win,
  input  logic pos_late,
  output logic accept,
  output logic miss
);
  logic used_q;

  assign accept = det & (searching | (in_win & ~used_q));
  assign miss   = ~searching & pos_late & ~used_q & ~det;

  always_ff @(posedge clk) begin
    if (rst)           used_q <= 1'b0;
    else if (accept)   used_q <= 1'b1;
    else if (pos_late) used_q <= 1'b0;
  end
endmodule

// File: rtl/fsync_fsm.sv
// Search / check / lock state machine with hit counting.
module fsync_fsm
  import fsync_pkg::*;
#(
  parameter int LOCK_HITS = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  logic      miss,
  output fs_state_e state_q,
  output logic      lock_q,
  output logic      searching
);
  localparam int HIT_W = (LOCK_HITS < 2) ? 1 : $clog2(LOCK_HITS);
  localparam logic [HIT_W-1:0] HIT_LAST = HIT_W'(LOCK_HITS - 1);

  fs_state_e        state_d;
  logic [HIT_W-1:0] hits_q, hits_d;

  always_comb begin
    state_d = state_q;
    hits_d  = hits_q;
    case (state_q)
      FS_SEARCH: if (accept) begin
        state_d = FS_CHECK;
        hits_d  = '0;
      end
      FS_CHECK: begin
        if (accept) begin
          if (hits_q == HIT_LAST) begin
            state_d = FS_LOCK;
            hits_d  = '0;
          end else begin
            hits_d = hits_q + 1'b1;
          end
        end else if (miss) begin
          state_d = FS_SEARCH;
          hits_d  = '0;
        end
      end
      FS_LOCK: if (miss) begin
        state_d = FS_CHECK;
        hits_d  = HIT_LAST;  // one hit restores lock
      end
      default: begin
        state_d = FS_SEARCH;
        hits_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_SEARCH;
      hits_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hits_q  <= hits_d;
      lock_q  <= (state_d == FS_LOCK);
    end
  end

  assign searching = (state_q == FS_SEARCH);
endmodule

// File: rtl/fsync_flywheel.sv
module fsync_flywheel
  import fsync_pkg::*;
#(
  parameter int FRAME_BITS = 19200,
  parameter int CENTER_POS = 19198,
  parameter int LOCK_HITS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_det_i,
  output logic [1:0] state_o,
  output logic       locked_o,
  output logic       frame_start_o,
  output logic       slip_o,
  output logic       slip_late_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic      pos_early, pos_center, pos_late, in_win;
  logic      accept, miss, searching, lock_q;
  fs_state_e state_q;
  logic      fs_q, slip_q, late_q;

  fsync_frame_ctr #(
    .FRAME_BITS(FRAME_BITS), .CENTER_POS(CENTER_POS), .CNT_W(CNT_W)
  ) u_ctr (
    .clk(clk), .rst(rst), .realign(accept),
    .pos_early(pos_early), .pos_center(pos_center),
    .pos_late(pos_late), .in_win(in_win)
  );

  fsync_window_gate u_gate (
    .clk(clk), .rst(rst), .searching(searching), .det(sync_det_i),
    .in_win(in_win), .pos_late(pos_late), .accept(accept), .miss(miss)
  );

  fsync_fsm #(.LOCK_HITS(LOCK_HITS)) u_fsm (
    .clk(clk), .rst(rst), .accept(accept), .miss(miss),
    .state_q(state_q), .lock_q(lock_q), .searching(searching)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= 1'b0;
      slip_q <= 1'b0;
      late_q <= 1'b0;
    end else begin
      fs_q   <= accept;
      slip_q <= accept & ~searching & ~pos_center;
      late_q <= accept & ~searching & pos_late;
    end
  end

  assign state_o       = state_q;
  assign locked_o      = lock_q;
  assign frame_start_o = fs_q;
  assign slip_o        = slip_q;
  assign slip_late_o   = late_q;
endmodule

// File: rtl/fsync_flywheel_chk.sv
module fsync_flywheel_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync_det_i,
  input logic [1:0] state_o,
  input logic       locked_o,
  input logic       frame_start_o,
  input logic       slip_o,
  input logic       slip_late_o
);
  // R12
  lock_flag_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o == (state_o == 2'd2));
  // R2
  acquire_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && sync_det_i) |=> (state_o == 2'd1 && frame_start_o));
  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);
  // R8
  slip_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    slip_o |-> (frame_start_o && state_o != 2'd0));
  // R8
  slip_dir_chk: assert property (@(posedge clk) disable iff (rst)
    slip_late_o |-> slip_o);
  // R6
  lock_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |=> (state_o != 2'd0));
  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> frame_start_o);
endmodule

bind fsync_flywheel fsync_flywheel_chk u_chk (
  .clk(clk), .rst(rst), .sync_det_i(sync_det_i), .state_o(state_o),
  .locked_o(locked_o), .frame_start_o(frame_start_o), .slip_o(slip_o),
  .slip_late_o(slip_late_o)
);

// File: tb/fsync_flywheel_test.sv
`timescale 1ns/1ps
module fsync_flywheel_test;
  localparam int F  = 48;
  localparam int C  = 46;
  localparam int LH = 2;
  localparam logic [1:0] S_SRCH = 2'd0, S_CHK = 2'd1, S_LCK = 2'd2;

  logic clk = 1'b0, rst = 1'b1, det = 1'b0;
  logic [1:0] state_o;
  logic locked_o, frame_start_o, slip_o, slip_late_o;

  always #2.5 clk = ~clk;

  fsync_flywheel #(.FRAME_BITS(F), .CENTER_POS(C), .LOCK_HITS(LH)) uut (
    .clk(clk), .rst(rst), .sync_det_i(det), .state_o(state_o),
    .locked_o(locked_o), .frame_start_o(frame_start_o), .slip_o(slip_o),
    .slip_late_o(slip_late_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // reference model
  int t = 0, mexp = 0, mh = 0;
  logic [1:0] ms = S_SRCH;
  logic e_fs = 0, e_sl = 0, e_sll = 0;

  function automatic logic [5:0] exp_vec();
    return {ms, ms == S_LCK, e_fs, e_sl, e_sll};
  endfunction

  task automatic compare(input string tag, input logic [5:0] e);
    logic [5:0] a;
    a = {state_o, locked_o, frame_start_o, slip_o, slip_late_o};
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, a, e);
    end
  endtask

  task automatic model(input logic d);
    e_fs = 0; e_sl = 0; e_sll = 0;
    if (ms == S_SRCH) begin
      if (d) begin ms = S_CHK; mh = 0; mexp = t + F; e_fs = 1; end
    end else if (d && t >= mexp - 1 && t <= mexp + 1) begin
      e_fs = 1; e_sl = (t != mexp); e_sll = (t == mexp + 1);
      mexp = t + F;
      if (ms == S_CHK) begin
        if (mh == LH - 1) begin ms = S_LCK; mh = 0; end
        else mh++;
      end
    end else if (t == mexp + 1) begin
      mexp = mexp + F;
      if (ms == S_CHK) ms = S_SRCH;
      else begin ms = S_CHK; mh = LH - 1; end
    end
  endtask

  task automatic step(input logic d, input string tag);
    @(negedge clk);
    det = d;
    @(posedge clk);
    model(d);
    t++;
    #1;
    compare(tag, exp_vec());
  endtask

  task automatic go_to(input int target, input string tag);
    while (t < target) step(1'b0, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; det = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    compare(tag, 6'b0);
    @(negedge clk);
    rst = 1'b0;
    ms = S_SRCH; mh = 0; e_fs = 0; e_sl = 0; e_sll = 0;
  endtask

  initial begin
    int gen_t;
    void'($urandom(32'd1357));
    do_reset("R1");
    repeat (5) step(1'b0, "R1");
    step(1'b1, "R2");                 // acquire
    go_to(mexp - 10, "R9");
    step(1'b1, "R9");                 // outside window: ignored
    go_to(mexp, "R9");
    step(1'b1, "R3");                 // on-time hit 1
    step(1'b1, "R10");                // second detect in same window
    go_to(mexp - 1, "R7");
    step(1'b1, "R8");                 // early hit -> lock, slip early
    go_to(mexp + 1, "R7");
    step(1'b1, "R8");                 // late hit, slip late
    go_to(mexp + 2, "R5");            // miss -> check
    go_to(mexp, "R5");
    step(1'b1, "R5");                 // single hit -> lock again
    go_to(mexp + 2, "R6");            // miss -> check
    go_to(mexp + 2, "R6");            // miss -> search
    step(1'b1, "R2");
    go_to(mexp + 2, "R4");            // miss in check -> search
    step(1'b1, "R2");
    go_to(mexp - 2, "R7");
    step(1'b1, "R7");                 // two early: ignored
    step(1'b1, "R7");                 // one early: taken
    go_to(mexp, "R12");
    step(1'b1, "R12");                // lock
    do_reset("R1");                   // reset from lock
    // random phase
    gen_t = t + 7;
    for (int i = 0; i < 4000; i++) begin
      logic d;
      d = 1'b0;
      if (t == gen_t) begin
        d = ($urandom % 100) < 85;
        gen_t = gen_t + F + ((($urandom % 4) == 0) ? (int'($urandom % 3) - 1) : 0);
      end
      if (($urandom % 100) < 3) d = 1'b1;
      step(d, "R11");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule